// File: doc/BRIEF.md
# Configuration Page Access Checker

This block sits in front of a 64 KB configuration flash window. The window is sixteen 4 KB pages split evenly over two panels. Each read, program, page-erase or debug-level-set request names a byte offset inside the window. The block works out the page from the top address bits and looks up that page's fixed class. It then combines the class with a set of sticky lock bits. The outcome is one of three: the request is forwarded to the flash sequencer, it is refused with a protection error, or it is answered with a bus error for an address hole.

A chip-erase pulse is not forwarded as a single operation. The block expands it into a walk over every page index and issues page erases only where a chip erase is allowed to reach. The walk skips one-time-programmable, calibration, test, debug-level and reserved pages. A page whose write lock is set is skipped as well. While the walk runs, the block accepts no other request.

Top module: `cfgchk_access_filter`

## Requirements
- R1: The page index is offset bits [15:12]. A read of any page other than a reserved one is forwarded one cycle after acceptance with the same opcode and offset. It is answered with code 0 (OK). Opcodes: 0 read, 1 program, 2 page erase, 3 set debug level.
- R2: Pages 3, 11, 12, 13, 14 and 15 are holes. Every opcode aimed at them returns code 1 (bus error) and forwards nothing.
- R3: Pages 5, 6 and 7 (test and the two calibration pages) forward reads only. Program, page erase and set debug level return code 2 (protection error) and forward nothing.
- R4: On page 4 (debug level), set debug level and read are forwarded, while program and page erase return code 2. Set debug level aimed at any other non-hole page returns code 2.
- R5: Pages 1 and 9 (user OTP) forward read and program. Page erase always returns code 2.
- R6: Pages 0 and 8 (user configuration) always forward reads. Program and page erase return code 2 while write-lock bit 0 (page 0) or bit 1 (page 8) is set.
- R7: On pages 2 and 10 (boot configuration), write-lock bit 2 (page 2) or bit 3 (page 10) blocks program and page erase. Read-lock bit 4 (page 2) or bit 5 (page 10) blocks reads. Blocked requests return code 2.
- R8: A bit that is high on lock_set becomes a lock from the next cycle on. A request accepted in the same cycle still sees the old lock state. A lock stays set until reset.
- R9: An accepted chip erase walks pages 0 to 15 one per cycle, starting the cycle after acceptance. It forwards page erases (offset = page × 4096) for pages 0, 2, 8 and 10 only, and skips any of them whose write lock is set. It answers code 0 together with the page-15 step.
- R10: req_ready is low while a walk runs and in any cycle where chip_erase is high. Requests offered then, and chip-erase pulses during a walk, get no response at all.
- R11: After reset all outputs are low, req_ready is high and every lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | Opcode: 0 read, 1 program, 2 page erase, 3 set debug level |
| req_addr | input | 16 | Byte offset in the window |
| chip_erase | input | 1 | Chip-erase start pulse |
| lock_set | input | 6 | Lock bits to set (0/1 user cfg write, 2/3 boot write, 4/5 boot read) |
| fwd_valid | output | 1 | Forwarded operation valid |
| fwd_op | output | 2 | Forwarded opcode |
| fwd_addr | output | 16 | Forwarded offset |
| rsp_valid | output | 1 | Decision response valid |
| rsp_code | output | 2 | 0 OK, 1 bus error, 2 protection error |

## Verification
Each of the four opcodes is sent to every page class, so a wrong class lookup or a wrong opcode rule shows up as a code or forwarding mismatch. The lock patterns come in three forms: a lock raised in the same cycle as a request, a lock raised on one panel's bit while the other panel's page is used, and a lock revisited after idle cycles. These separate the effect timing, the per-panel bit selection and the stickiness. Chip erase runs once with locks set and once after a reset with none. It also has requests and a second pulse injected mid-walk, which tells the skip rules apart from the busy gating.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;

   typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_SETDL = 2'd3} op_e;
   typedef enum logic [1:0] {RC_OK = 2'd0, RC_HOLE = 2'd1, RC_PROT = 2'd2} rc_e;
   typedef enum logic [2:0] {PK_HOLE, PK_UCFG, PK_OTP, PK_BOOT, PK_DLVL, PK_FIXED} kind_e;

   localparam int SLOTS_PER_PANEL = 8;
   localparam int NUM_LOCKS       = 6;
   localparam int LK_UCFG_WR      = 0;
   localparam int LK_BOOT_WR      = 2;
   localparam int LK_BOOT_RD      = 4;

   // Class of a page from its slot inside a panel and the panel it lives in.
   function automatic kind_e slot_kind(input logic [2:0] slot, input logic second_panel);
      kind_e k;
      case (slot)
         3'd0: k = PK_UCFG;
         3'd1: k = PK_OTP;
         3'd2: k = PK_BOOT;
         3'd4: k = second_panel ? PK_HOLE : PK_DLVL;
         3'd5, 3'd6, 3'd7: k = second_panel ? PK_HOLE : PK_FIXED;
         default: k = PK_HOLE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/cfgchk_page_map.sv
module cfgchk_page_map
   import cfgchk_pkg::*;
#(
   parameter int PAGES = 16,
   localparam int IDX_W = $clog2(PAGES)
) (
   input  logic [IDX_W-1:0] page_idx,
   output kind_e            kind,
   output logic             panel
);

   if (PAGES != 2 * SLOTS_PER_PANEL) begin : g_bad_pages
      $error("cfgchk_page_map: PAGES must equal two panels of slots");
   end

   kind_e kind_tab [PAGES];

   for (genvar p = 0; p < PAGES; p++) begin : g_page
      assign kind_tab[p] = slot_kind(3'(p % SLOTS_PER_PANEL), (p >= SLOTS_PER_PANEL));
   end

   assign kind  = kind_tab[page_idx];
   assign panel = page_idx[IDX_W-1];

endmodule

// File: rtl/cfgchk_lock_bank.sv
module cfgchk_lock_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   output logic [N-1:0] lock_o
);

   if (N < 1) begin : g_bad_n
      $error("cfgchk_lock_bank: N must be positive");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= 1'b0;
         else if (set_i[i]) q <= 1'b1;
      end
      assign lock_o[i] = q;
   end

endmodule

// File: rtl/cfgchk_rule_eval.sv
module cfgchk_rule_eval
   import cfgchk_pkg::*;
(
   input  op_e                  op,
   input  kind_e                kind,
   input  logic                 panel,
   input  logic [NUM_LOCKS-1:0] locks,
   output logic                 pass,
   output rc_e                  code
);

   logic wr_lock, rd_lock, is_rd, is_mod;

   always_comb begin
      wr_lock = 1'b0;
      rd_lock = 1'b0;
      if (kind == PK_UCFG) wr_lock = locks[LK_UCFG_WR + int'(panel)];
      if (kind == PK_BOOT) begin
         wr_lock = locks[LK_BOOT_WR + int'(panel)];
         rd_lock = locks[LK_BOOT_RD + int'(panel)];
      end
   end

   assign is_rd  = (op == OP_READ);
   assign is_mod = (op == OP_PROG) || (op == OP_ERASE);

   always_comb begin
      pass = 1'b0;
      case (kind)
         PK_HOLE:  pass = 1'b0;
         PK_FIXED: pass = is_rd;
         PK_DLVL:  pass = is_rd || (op == OP_SETDL);
         PK_OTP:   pass = is_rd || (op == OP_PROG);
         PK_UCFG:  pass = is_rd || (is_mod && !wr_lock);
         PK_BOOT:  pass = (is_rd && !rd_lock) || (is_mod && !wr_lock);
         default:  pass = 1'b0;
      endcase
      if (kind == PK_HOLE) code = RC_HOLE;
      else if (pass)       code = RC_OK;
      else                 code = RC_PROT;
   end

endmodule

// File: rtl/cfgchk_chip_walk.sv
module cfgchk_chip_walk
   import cfgchk_pkg::*;
#(
   parameter int PAGES = 16,
   parameter bit LOCKS_GUARD = 1'b1,
   localparam int IDX_W = $clog2(PAGES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [NUM_LOCKS-1:0] locks,
   output logic                 busy,
   output logic                 emit,
   output logic                 last,
   output logic [IDX_W-1:0]     idx
);

   logic [IDX_W-1:0] idx_q;
   logic             busy_q;
   kind_e            cur_kind;
   logic             cur_panel;
   logic             cfg_page, locked;

   assign cur_panel = idx_q[IDX_W-1];
   assign cur_kind  = slot_kind(idx_q[2:0], cur_panel);
   assign cfg_page  = (cur_kind == PK_UCFG) || (cur_kind == PK_BOOT);

   if (LOCKS_GUARD) begin : g_guard
      always_comb begin
         locked = 1'b0;
         if (cur_kind == PK_UCFG) locked = locks[LK_UCFG_WR + int'(cur_panel)];
         if (cur_kind == PK_BOOT) locked = locks[LK_BOOT_WR + int'(cur_panel)];
      end
   end else begin : g_override
      assign locked = 1'b0;
   end

   assign emit = busy_q && cfg_page && !locked;
   assign last = busy_q && (idx_q == IDX_W'(PAGES - 1));
   assign busy = busy_q;
   assign idx  = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
         end
      end else begin
         idx_q <= idx_q + 1'b1;
         if (last) busy_q <= 1'b0;
      end
   end

endmodule

// File: rtl/cfgchk_access_filter.sv
module cfgchk_access_filter
   import cfgchk_pkg::*;
#(
   parameter int PAGE_LOG2 = 12,
   parameter int PAGES = 16,
   parameter bit LOCKS_GUARD_CHIP_ERASE = 1'b1,
   localparam int IDX_W = $clog2(PAGES),
   localparam int ADDR_W = PAGE_LOG2 + IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [1:0]           req_op,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic                 chip_erase,
   input  logic [NUM_LOCKS-1:0] lock_set,
   output logic                 fwd_valid,
   output logic [1:0]           fwd_op,
   output logic [ADDR_W-1:0]    fwd_addr,
   output logic                 rsp_valid,
   output logic [1:0]           rsp_code
);

   if (PAGE_LOG2 < 1) begin : g_bad_page
      $error("cfgchk_access_filter: PAGE_LOG2 must be positive");
   end

   logic [NUM_LOCKS-1:0] lock_q;
   logic                 busy, w_emit, w_last;
   logic [IDX_W-1:0]     w_idx;
   kind_e                kind;
   logic                 panel, pass, accept, start;
   rc_e                  code;

   cfgchk_page_map #(.PAGES(PAGES)) u_map (
      .page_idx (req_addr[ADDR_W-1 -: IDX_W]),
      .kind     (kind),
      .panel    (panel)
   );

   cfgchk_lock_bank #(.N(NUM_LOCKS)) u_locks (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (lock_set),
      .lock_o (lock_q)
   );

   cfgchk_rule_eval u_rules (
      .op    (op_e'(req_op)),
      .kind  (kind),
      .panel (panel),
      .locks (lock_q),
      .pass  (pass),
      .code  (code)
   );

   cfgchk_chip_walk #(.PAGES(PAGES), .LOCKS_GUARD(LOCKS_GUARD_CHIP_ERASE)) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .locks (lock_q),
      .busy  (busy),
      .emit  (w_emit),
      .last  (w_last),
      .idx   (w_idx)
   );

   assign req_ready = !busy && !chip_erase;
   assign accept    = req_valid && req_ready;
   assign start     = chip_erase && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_valid <= 1'b0;
         fwd_op    <= '0;
         fwd_addr  <= '0;
         rsp_valid <= 1'b0;
         rsp_code  <= '0;
      end else if (busy) begin
         fwd_valid <= w_emit;
         rsp_valid <= w_last;
         rsp_code  <= RC_OK;
         if (w_emit) begin
            fwd_op   <= OP_ERASE;
            fwd_addr <= {w_idx, {PAGE_LOG2{1'b0}}};
         end
      end else if (accept) begin
         fwd_valid <= pass;
         rsp_valid <= 1'b1;
         rsp_code  <= code;
         if (pass) begin
            fwd_op   <= req_op;
            fwd_addr <= req_addr;
         end
      end else begin
         fwd_valid <= 1'b0;
         rsp_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/cfgchk_access_sva.sv
module cfgchk_access_sva #(
   parameter int IDX_W = 4,
   parameter int NL = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [IDX_W-1:0] req_page,
   input logic             fwd_valid,
   input logic [1:0]       fwd_op,
   input logic [IDX_W-1:0] fwd_page,
   input logic             rsp_valid,
   input logic [1:0]       rsp_code,
   input logic [NL-1:0]    lock_q,
   input logic             busy
);

   logic req_hole, fwd_fixed, fwd_cfg;
   assign req_hole  = (req_page == IDX_W'(3)) || (req_page >= IDX_W'(11));
   assign fwd_fixed = (fwd_page >= IDX_W'(5)) && (fwd_page <= IDX_W'(7));
   assign fwd_cfg   = (fwd_page == IDX_W'(0)) || (fwd_page == IDX_W'(2)) ||
                      (fwd_page == IDX_W'(8)) || (fwd_page == IDX_W'(10));

   AST_HOLE_BUSERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_hole) |=> (rsp_valid && rsp_code == 2'd1 && !fwd_valid)); // R2

   AST_FIXED_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_fixed) |-> (fwd_op == 2'd0)); // R3

   AST_DLVL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_page == IDX_W'(4)) |-> (fwd_op == 2'd0 || fwd_op == 2'd3)); // R4

   AST_OTP_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_op == 2'd2) |-> (fwd_page != IDX_W'(1) && fwd_page != IDX_W'(9))); // R5

   AST_WALK_CFG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && fwd_valid) |-> (fwd_op == 2'd2 && fwd_cfg)); // R9

   for (genvar i = 0; i < NL; i++) begin : g_sticky
      AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         lock_q[i] |=> lock_q[i]); // R8
   end

endmodule

bind cfgchk_access_filter cfgchk_access_sva #(.IDX_W(IDX_W), .NL(cfgchk_pkg::NUM_LOCKS)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_page  (req_addr[ADDR_W-1 -: IDX_W]),
   .fwd_valid (fwd_valid),
   .fwd_op    (fwd_op),
   .fwd_page  (fwd_addr[ADDR_W-1 -: IDX_W]),
   .rsp_valid (rsp_valid),
   .rsp_code  (rsp_code),
   .lock_q    (lock_q),
   .busy      (busy)
);

// File: tb/cfgchk_access_filter_test.sv
`timescale 1ns/1ps
module cfgchk_access_filter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = '0;
   logic [15:0] req_addr = '0;
   logic        chip_erase = 1'b0;
   logic [5:0]  lock_set = '0;
   logic        fwd_valid;
   logic [1:0]  fwd_op;
   logic [15:0] fwd_addr;
   logic        rsp_valid;
   logic [1:0]  rsp_code;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   // reference model state
   bit [5:0] m_lock;
   bit       m_busy;
   int       m_idx;

   always #2.5 clk = ~clk;

   cfgchk_access_filter uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .chip_erase(chip_erase), .lock_set(lock_set),
      .fwd_valid(fwd_valid), .fwd_op(fwd_op), .fwd_addr(fwd_addr),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code)
   );

   // 0 hole, 1 user cfg, 2 otp, 3 boot cfg, 4 debug level, 5 fixed
   function automatic int kind_of(int p);
      if (p == 0 || p == 8)  return 1;
      if (p == 1 || p == 9)  return 2;
      if (p == 2 || p == 10) return 3;
      if (p == 4)            return 4;
      if (p >= 5 && p <= 7)  return 5;
      return 0;
   endfunction

   // returns response code; OK means forwarded
   function automatic int decide(int op, int pg);
      int k = kind_of(pg);
      int pn = pg / 8;
      case (k)
         0: return 1;
         5: return (op == 0) ? 0 : 2;
         4: return (op == 0 || op == 3) ? 0 : 2;
         2: return (op == 0 || op == 1) ? 0 : 2;
         1: begin
            if (op == 0) return 0;
            if (op == 3) return 2;
            return m_lock[pn] ? 2 : 0;
         end
         default: begin
            if (op == 0) return m_lock[4+pn] ? 2 : 0;
            if (op == 3) return 2;
            return m_lock[2+pn] ? 2 : 0;
         end
      endcase
   endfunction

   task automatic step(input bit v, input int op, input int addr, input bit ce,
                       input bit [5:0] lk, input string tag);
      bit efv, erv, erdy;
      int efop, efaddr, erc;
      @(negedge clk);
      req_valid = v; req_op = 2'(op); req_addr = 16'(addr); chip_erase = ce; lock_set = lk;
      #1;
      erdy = !m_busy && !ce;
      efv = 0; erv = 0; efop = 0; efaddr = 0; erc = 0;
      if (m_busy) begin
         int k = kind_of(m_idx);
         efv = (k == 1 && !m_lock[m_idx/8]) || (k == 3 && !m_lock[2 + m_idx/8]);
         efop = 2; efaddr = m_idx * 4096;
         erv = (m_idx == 15);
         if (m_idx == 15) m_busy = 0;
         m_idx++;
      end else if (ce) begin
         m_busy = 1; m_idx = 0;
      end else if (v) begin
         erc = decide(op, addr / 4096);
         erv = 1; efv = (erc == 0); efop = op; efaddr = addr;
      end
      m_lock = m_lock | lk;
      compared++;
      if (req_ready !== erdy) begin
         mismatched++;
         $display("FAIL %s: req_ready=%0d expected %0d", tag, req_ready, erdy);
      end
      @(posedge clk);
      #1;
      compared++;
      if (fwd_valid !== efv || rsp_valid !== erv ||
          (efv && (fwd_op !== 2'(efop) || fwd_addr !== 16'(efaddr))) ||
          (erv && rsp_code !== 2'(erc))) begin
         mismatched++;
         $display("FAIL %s: fwd_v=%0d op=%0d addr=%h rsp_v=%0d code=%0d expected fwd_v=%0d op=%0d addr=%h rsp_v=%0d code=%0d",
                  tag, fwd_valid, fwd_op, fwd_addr, rsp_valid, rsp_code, efv, efop, efaddr, erv, erc);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; req_valid = 0; chip_erase = 0; lock_set = '0;
      m_lock = '0; m_busy = 0; m_idx = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      compared++;
      if (fwd_valid !== 1'b0 || rsp_valid !== 1'b0 || req_ready !== 1'b1 ||
          fwd_op !== 2'd0 || fwd_addr !== 16'd0 || rsp_code !== 2'd0) begin
         mismatched++;
         $display("FAIL R11: fwd_v=%0d rsp_v=%0d ready=%0d op=%0d addr=%h code=%0d expected 0 0 1 0 0000 0",
                  fwd_valid, rsp_valid, req_ready, fwd_op, fwd_addr, rsp_code);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: run did not end, actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      do_reset(); // R11
      for (int p = 0; p < 16; p++)
         if (kind_of(p) != 0) step(1, 0, p * 4096 + 16'h0123, 0, 0, "R1");
      step(0, 0, 0, 0, 0, "R1");
      foreach (m_lock[i]) ; // no-op keeps model untouched
      for (int p = 0; p < 16; p++)
         if (kind_of(p) == 0)
            for (int op = 0; op < 4; op++) step(1, op, p * 4096 + op * 4, 0, 0, "R2");
      for (int p = 5; p <= 7; p++)
         for (int op = 0; op < 4; op++) step(1, op, p * 4096 + 8, 0, 0, "R3");
      for (int op = 0; op < 4; op++) step(1, op, 4 * 4096 + 16'h40, 0, 0, "R4");
      step(1, 3, 0, 0, 0, "R4");
      step(1, 3, 9 * 4096, 0, 0, "R4");
      step(1, 3, 10 * 4096, 0, 0, "R4");
      for (int p = 1; p <= 9; p += 8)
         for (int op = 0; op < 3; op++) step(1, op, p * 4096 + 16'h200, 0, 0, "R5");
      step(1, 1, 16'h0010, 0, 0, "R6");
      step(0, 0, 0, 0, 6'b000001, "R6");
      step(1, 1, 16'h0010, 0, 0, "R6");
      step(1, 2, 16'h0000, 0, 0, "R6");
      step(1, 0, 16'h0010, 0, 0, "R6");
      step(1, 1, 8 * 4096 + 16'h10, 0, 0, "R6");
      step(1, 1, 10 * 4096 + 4, 0, 6'b001000, "R8");
      step(1, 1, 10 * 4096 + 4, 0, 0, "R8");
      repeat (3) step(0, 0, 0, 0, 0, "R8");
      step(1, 2, 10 * 4096, 0, 0, "R8");
      step(1, 1, 2 * 4096, 0, 0, "R8");
      step(1, 0, 2 * 4096 + 16'h30, 0, 0, "R7");
      step(0, 0, 0, 0, 6'b010000, "R7");
      step(1, 0, 2 * 4096 + 16'h30, 0, 0, "R7");
      step(1, 0, 10 * 4096 + 16'h30, 0, 0, "R7");
      step(1, 1, 2 * 4096 + 16'h30, 0, 0, "R7");
      step(0, 0, 0, 0, 6'b000100, "R7");
      step(1, 2, 2 * 4096, 0, 0, "R7");
      step(0, 0, 0, 0, 6'b100000, "R7");
      step(1, 0, 10 * 4096, 0, 0, "R7");
      // chip erase with locks 0,2,3 set: only page 8 erased
      step(1, 0, 0, 1, 0, "R10");
      for (int c = 0; c < 16; c++) step(c % 3 == 0, 0, 16'h0000, c == 5, 0, "R9");
      step(0, 0, 0, 0, 0, "R9");
      do_reset();
      step(1, 1, 16'h0020, 0, 0, "R8");
      step(1, 0, 2 * 4096, 0, 0, "R8");
      step(0, 0, 0, 1, 0, "R9");
      for (int c = 0; c < 16; c++) step(c == 7, 1, 16'h0040, 0, 0, "R10");
      step(1, 1, 16'h0040, 0, 0, "R10");
      step(0, 0, 0, 0, 0, "R10");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule